// File: doc/BRIEF.md
# COBS Framed Serial Link Bridge

This block sits between a byte-wide serial link to a host and the message path of a CAN controller node. On the way out it accepts a message of one to twelve bytes and appends a checksum byte chosen so that the message bytes and the checksum add to zero modulo 256. It then encodes the result as a single COBS block, so that no zero byte appears inside the frame, and closes the frame with a 0x00 delimiter. The serial link runs at the same rate as the CAN bus, so one byte every 10 µs is the slowest the stream can be allowed to run. This block produces or takes a byte per clock and never sets that pace.

On the way in it decodes COBS frames, holds the decoded bytes until the delimiter arrives, and checks the checksum. A good message whose first byte is 0xFF is a command for the local controller and leaves on the local port, including the 0xFF byte. Every other good message leaves unchanged on the CAN-side port. The checksum byte is stripped in both cases. Bad frames are dropped and flagged with a one-cycle error pulse. Empty frames (back-to-back delimiters) are ignored.

Every byte stream uses valid/ready. A transfer happens on a rising edge where both are high. A source holds its data and valid until the transfer happens. `msg_ready` stays low from the last message byte until the delimiter has been taken. `rxs_ready` stays low while a decoded message is being handed out.

Top module: `cobs_link_bridge`

## Requirements
- R1: The byte appended to each outgoing message is the two's complement of the 8-bit sum of the message bytes.
- R2: Each outgoing frame is one COBS block. A code byte comes first. Each zero of the message-plus-checksum is replaced by the distance to the next zero, or to the end of the block. No 0x00 appears before the single closing 0x00.
- R3: When an outgoing message is longer than 12 bytes, only its first 12 bytes are framed and checksummed. The rest are accepted and discarded.
- R4: After reset `msg_ready` is high and `txs_valid` is low. While `txs_valid` is high and `txs_ready` low, `txs_data` holds. `msg_ready` is low from the accepted last byte until the delimiter is accepted.
- R5: A frame that decodes to at least two bytes, has a zero-sum checksum and a first byte other than 0xFF appears on the CAN port. The bytes come out unchanged and in order, without the checksum, with `can_last` on the final byte. The first byte is offered the cycle after the delimiter is accepted.
- R6: Such a frame whose first byte is 0xFF appears in the same form on the local port, 0xFF included, and nothing appears on the CAN port.
- R7: A frame whose decoded bytes do not sum to zero is dropped and raises `frame_err` for exactly one cycle.
- R8: A frame that decodes to more than 13 bytes is dropped with one error pulse. All bytes up to the next 0x00 are discarded.
- R9: A delimiter that arrives while the current code byte still promises data bytes drops the frame with one error pulse. That delimiter also ends the frame, so the next byte starts a new frame.
- R10: Consecutive delimiters produce no output and no error. A frame that decodes to fewer than two bytes is dropped with one error pulse.
- R11: After reset `rxs_ready` is high and both output ports are idle. While a decoded message is offered and not taken, its data and last flag hold and `rxs_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_data | input | 8 | Outgoing message byte |
| msg_last | input | 1 | Marks the final byte of the outgoing message |
| msg_valid | input | 1 | Outgoing message byte valid |
| msg_ready | output | 1 | Block accepts an outgoing message byte |
| txs_data | output | 8 | Encoded byte toward the serial transmitter |
| txs_valid | output | 1 | Encoded byte valid |
| txs_ready | input | 1 | Serial transmitter accepts a byte |
| rxs_data | input | 8 | Received serial byte |
| rxs_valid | input | 1 | Received byte valid |
| rxs_ready | output | 1 | Block accepts a received byte |
| can_data | output | 8 | Decoded byte for the CAN side |
| can_last | output | 1 | Final byte of the CAN-side message |
| can_valid | output | 1 | CAN-side byte valid |
| can_ready | input | 1 | CAN side accepts a byte |
| ctl_data | output | 8 | Decoded byte for the local controller |
| ctl_last | output | 1 | Final byte of the local message |
| ctl_valid | output | 1 | Local byte valid |
| ctl_ready | input | 1 | Local controller accepts a byte |
| frame_err | output | 1 | One-cycle pulse when a received frame is dropped |

## Verification
The first encoded byte is offered the cycle after the last message byte is accepted. The first decoded byte is offered the cycle after the delimiter is accepted. `frame_err` rises the cycle after the offending byte is taken. After that, every path moves one byte per cycle in which ready is high. The bench drives inputs just after a rising edge. It samples every handshake and the error pulse at the falling edge, so each transfer and each pulse is counted exactly once. Expected bytes are queued in order, and each byte is compared as soon as it is transferred rather than at a fixed cycle. This keeps the checks valid under the random back-pressure applied to both output sides. The error pulse count and the empty queues are compared after each stream has drained.

// File: rtl/cobs_bridge_pkg.sv
package cobs_bridge_pkg;
  typedef enum logic [1:0] {E_LOAD, E_SEND, E_DELIM} enc_st_e;
  typedef enum logic [1:0] {D_IDLE, D_BODY, D_DROP, D_EMIT} dec_st_e;
  localparam logic [7:0] LOCAL_TAG = 8'hFF;
endpackage

// File: rtl/cobs_frame_enc.sv
module cobs_frame_enc
  import cobs_bridge_pkg::*;
#(
  parameter int MSG_MAX = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready
);
  localparam int BUF   = MSG_MAX + 1;
  localparam int IW    = $clog2(BUF + 1);
  localparam int DEPTH = 1 << IW;

  enc_st_e          st_q;
  logic [7:0]       buf_q [DEPTH];
  logic [IW-1:0]    cnt_q, len_q, pos_q, cnt_n, prev, zero_at;
  logic [7:0]       sum_q, sum_n, code;
  logic             take;

  assign in_ready = (st_q == E_LOAD);
  assign take     = (cnt_q < IW'(MSG_MAX));
  assign sum_n    = sum_q + (take ? in_data : 8'h00);
  assign cnt_n    = cnt_q + IW'(take);
  assign prev     = pos_q - IW'(1);

  // nearest zero at or after the current position, else end of block
  always_comb begin
    zero_at = len_q;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (IW'(j) >= pos_q && IW'(j) < len_q && buf_q[j] == 8'h00) zero_at = IW'(j);
    end
  end
  assign code = 8'(zero_at - pos_q) + 8'd1;

  always_comb begin
    out_valid = (st_q != E_LOAD);
    if (st_q == E_DELIM)             out_data = 8'h00;
    else if (pos_q == '0)            out_data = code;
    else if (buf_q[prev] == 8'h00)   out_data = code;
    else                             out_data = buf_q[prev];
  end

  always_ff @(posedge clk) begin
    if (st_q == E_LOAD && in_valid) begin
      if (take) buf_q[cnt_q] <= in_data;
      if (in_last) buf_q[cnt_n] <= 8'h00 - sum_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= E_LOAD;
      cnt_q <= '0;
      len_q <= '0;
      pos_q <= '0;
      sum_q <= 8'h00;
    end else begin
      case (st_q)
        E_LOAD: if (in_valid) begin
          cnt_q <= cnt_n;
          sum_q <= sum_n;
          if (in_last) begin
            len_q <= cnt_n + IW'(1);
            pos_q <= '0;
            st_q  <= E_SEND;
          end
        end
        E_SEND: if (out_ready) begin
          if (pos_q == len_q) st_q <= E_DELIM;
          else                pos_q <= pos_q + IW'(1);
        end
        default: if (out_ready) begin
          st_q  <= E_LOAD;
          cnt_q <= '0;
          sum_q <= 8'h00;
        end
      endcase
    end
  end

  // R2
  no_zero_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && st_q == E_SEND) |-> (out_data != 8'h00));
  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R4
  reopen_after_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && st_q == E_DELIM) |=> in_ready);
endmodule

// File: rtl/cobs_frame_dec.sv
module cobs_frame_dec
  import cobs_bridge_pkg::*;
#(
  parameter int MSG_MAX = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] can_data,
  output logic       can_last,
  output logic       can_valid,
  input  logic       can_ready,
  output logic [7:0] ctl_data,
  output logic       ctl_last,
  output logic       ctl_valid,
  input  logic       ctl_ready,
  output logic       err
);
  localparam int BUF   = MSG_MAX + 1;
  localparam int IW    = $clog2(BUF + 1);
  localparam int DEPTH = 1 << IW;

  dec_st_e       st_q;
  logic [7:0]    buf_q [DEPTH];
  logic [IW-1:0] cnt_q, pos_q;
  logic [7:0]    rem_q, sum_q, wr_data;
  logic          err_q, accept, full, to_ctl, at_last, take_out, wr_en;

  assign in_ready  = (st_q != D_EMIT);
  assign accept    = in_valid && in_ready;
  assign full      = (cnt_q == IW'(BUF));
  assign to_ctl    = (buf_q[0] == LOCAL_TAG);
  assign at_last   = (pos_q == cnt_q - IW'(2));
  assign can_valid = (st_q == D_EMIT) && !to_ctl;
  assign ctl_valid = (st_q == D_EMIT) && to_ctl;
  assign can_data  = buf_q[pos_q];
  assign ctl_data  = buf_q[pos_q];
  assign can_last  = at_last;
  assign ctl_last  = at_last;
  assign take_out  = (can_valid && can_ready) || (ctl_valid && ctl_ready);
  assign err       = err_q;

  // a code byte inside the body stands for the zero that ended the previous group
  assign wr_en   = (st_q == D_BODY) && accept && (in_data != 8'h00) && !full;
  assign wr_data = (rem_q == 8'h00) ? 8'h00 : in_data;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[cnt_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= D_IDLE;
      cnt_q <= '0;
      pos_q <= '0;
      rem_q <= 8'h00;
      sum_q <= 8'h00;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        D_IDLE: if (accept && in_data != 8'h00) begin
          rem_q <= in_data - 8'd1;
          cnt_q <= '0;
          sum_q <= 8'h00;
          st_q  <= D_BODY;
        end
        D_BODY: if (accept) begin
          if (in_data == 8'h00) begin
            if (rem_q != 8'h00 || cnt_q < IW'(2) || sum_q != 8'h00) begin
              err_q <= 1'b1;
              st_q  <= D_IDLE;
            end else begin
              pos_q <= '0;
              st_q  <= D_EMIT;
            end
          end else if (full) begin
            err_q <= 1'b1;
            st_q  <= D_DROP;
          end else begin
            cnt_q <= cnt_q + IW'(1);
            if (rem_q == 8'h00) begin
              rem_q <= in_data - 8'd1;
            end else begin
              rem_q <= rem_q - 8'd1;
              sum_q <= sum_q + in_data;
            end
          end
        end
        D_DROP: if (accept && in_data == 8'h00) st_q <= D_IDLE;
        default: if (take_out) begin
          if (at_last) st_q  <= D_IDLE;
          else         pos_q <= pos_q + IW'(1);
        end
      endcase
    end
  end

  // R7
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R11
  can_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (can_valid && !can_ready) |=> (can_valid && $stable(can_data) && $stable(can_last)));
  // R11
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data) && $stable(ctl_last)));
  // R5
  emit_after_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((can_valid || ctl_valid) && !$past(can_valid || ctl_valid))
      |-> $past(in_valid && in_ready && in_data == 8'h00));
endmodule

// File: rtl/cobs_link_bridge.sv
module cobs_link_bridge #(
  parameter int MSG_MAX = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] msg_data,
  input  logic       msg_last,
  input  logic       msg_valid,
  output logic       msg_ready,
  output logic [7:0] txs_data,
  output logic       txs_valid,
  input  logic       txs_ready,
  input  logic [7:0] rxs_data,
  input  logic       rxs_valid,
  output logic       rxs_ready,
  output logic [7:0] can_data,
  output logic       can_last,
  output logic       can_valid,
  input  logic       can_ready,
  output logic [7:0] ctl_data,
  output logic       ctl_last,
  output logic       ctl_valid,
  input  logic       ctl_ready,
  output logic       frame_err
);
  cobs_frame_enc #(.MSG_MAX(MSG_MAX)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .in_data(msg_data), .in_last(msg_last), .in_valid(msg_valid), .in_ready(msg_ready),
    .out_data(txs_data), .out_valid(txs_valid), .out_ready(txs_ready)
  );

  cobs_frame_dec #(.MSG_MAX(MSG_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .in_data(rxs_data), .in_valid(rxs_valid), .in_ready(rxs_ready),
    .can_data(can_data), .can_last(can_last), .can_valid(can_valid), .can_ready(can_ready),
    .ctl_data(ctl_data), .ctl_last(ctl_last), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .err(frame_err)
  );
endmodule

// File: tb/test_cobs_link_bridge.sv
module test_cobs_link_bridge;
  localparam int MSG_MAX = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [7:0] msg_data, txs_data, rxs_data, can_data, ctl_data;
  logic       msg_last, msg_valid, msg_ready, txs_valid, txs_ready;
  logic       rxs_valid, rxs_ready, can_last, can_valid, can_ready;
  logic       ctl_last, ctl_valid, ctl_ready, frame_err;

  cobs_link_bridge #(.MSG_MAX(MSG_MAX)) i_cobs_link_bridge (
    .clk(clk), .rst_n(rst_n),
    .msg_data(msg_data), .msg_last(msg_last), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .txs_data(txs_data), .txs_valid(txs_valid), .txs_ready(txs_ready),
    .rxs_data(rxs_data), .rxs_valid(rxs_valid), .rxs_ready(rxs_ready),
    .can_data(can_data), .can_last(can_last), .can_valid(can_valid), .can_ready(can_ready),
    .ctl_data(ctl_data), .ctl_last(ctl_last), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .frame_err(frame_err)
  );

  int n_chk = 0, n_fail = 0, err_seen = 0, err_exp = 0;
  logic [8:0] q_tx[$], q_can[$], q_ctl[$];
  logic [8:0] e_tx, e_can, e_ctl;
  logic [7:0] frm[$], m[$];
  logic bp_tx = 1'b0, bp_rx = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference framing built from the requirements: checksum, then COBS groups
  function automatic void encode(input logic [7:0] src[$]);
    logic [7:0] body[$];
    logic [7:0] grp[$];
    logic [7:0] s = 8'h00;
    frm.delete();
    for (int i = 0; i < src.size() && i < MSG_MAX; i++) begin
      body.push_back(src[i]);
      s += src[i];
    end
    body.push_back(8'h00 - s);
    foreach (body[i]) begin
      if (body[i] == 8'h00) begin
        frm.push_back(8'(grp.size() + 1));
        foreach (grp[k]) frm.push_back(grp[k]);
        grp.delete();
      end else grp.push_back(body[i]);
    end
    frm.push_back(8'(grp.size() + 1));
    foreach (grp[k]) frm.push_back(grp[k]);
    frm.push_back(8'h00);
  endfunction

  task automatic send_msg(input logic [7:0] src[$], input string tag);
    encode(src);
    foreach (frm[i]) q_tx.push_back({1'b0, frm[i]});
    foreach (src[i]) begin
      msg_data  = src[i];
      msg_last  = (i == src.size() - 1);
      msg_valid = 1'b1;
      do @(negedge clk); while (!msg_ready);
      @(posedge clk); #1;
    end
    msg_valid = 1'b0;
    msg_last  = 1'b0;
    @(negedge clk);
    chk({tag, " R4 msg_ready low while frame is sent"}, 32'(msg_ready), 32'd0);
  endtask

  task automatic rx_bytes(input logic [7:0] b[$]);
    foreach (b[i]) begin
      rxs_data  = b[i];
      rxs_valid = 1'b1;
      do @(negedge clk); while (!rxs_ready);
      @(posedge clk); #1;
    end
    rxs_valid = 1'b0;
  endtask

  task automatic rx_msg(input logic [7:0] src[$]);
    encode(src);
    foreach (src[i]) begin
      if (src[0] == 8'hFF) q_ctl.push_back({i == src.size() - 1, src[i]});
      else                 q_can.push_back({i == src.size() - 1, src[i]});
    end
    rx_bytes(frm);
  endtask

  task automatic rx_bad(input logic [7:0] b[$]);
    err_exp++;
    rx_bytes(b);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (q_tx.size() == 0 && q_can.size() == 0 && q_ctl.size() == 0) break;
      @(posedge clk);
    end
    repeat (6) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    txs_ready = bp_tx ? ($urandom % 3 != 0) : 1'b1;
    can_ready = bp_rx ? ($urandom % 3 != 0) : 1'b1;
    ctl_ready = bp_rx ? ($urandom % 2 != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (txs_valid && txs_ready) begin
        if (q_tx.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2 unexpected serial byte actual=%0h expected=none", txs_data);
        end else begin
          e_tx = q_tx.pop_front();
          chk("R1 R2 encoded byte", 32'(txs_data), 32'(e_tx[7:0]));
        end
      end
      if (can_valid && can_ready) begin
        if (q_can.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R5 unexpected CAN byte actual=%0h expected=none", {can_last, can_data});
        end else begin
          e_can = q_can.pop_front();
          chk("R5 CAN byte and last", 32'({can_last, can_data}), 32'(e_can));
        end
      end
      if (ctl_valid && ctl_ready) begin
        if (q_ctl.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R6 unexpected local byte actual=%0h expected=none", {ctl_last, ctl_data});
        end else begin
          e_ctl = q_ctl.pop_front();
          chk("R6 local byte and last", 32'({ctl_last, ctl_data}), 32'(e_ctl));
        end
      end
      if (frame_err) err_seen++;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL R4 R11 watchdog expired actual=stalled expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    msg_data = 8'h00; msg_last = 1'b0; msg_valid = 1'b0;
    rxs_data = 8'h00; rxs_valid = 1'b0;
    txs_ready = 1'b1; can_ready = 1'b1; ctl_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset msg_ready", 32'(msg_ready), 32'd1);
    chk("R4 reset txs_valid", 32'(txs_valid), 32'd0);
    chk("R11 reset rxs_ready", 32'(rxs_ready), 32'd1);
    chk("R11 reset outputs idle", 32'({can_valid, ctl_valid, frame_err}), 32'd0);
    @(posedge clk); #1;

    // transmit: plain, with zeros, zero checksum, single zero byte
    m = {8'h11, 8'h22, 8'h33};        send_msg(m, "R1");
    m = {8'h00, 8'h05, 8'h00};        send_msg(m, "R2");
    m = {8'h01, 8'hFF};               send_msg(m, "R1");
    m = {8'h00};                      send_msg(m, "R2");
    m.delete();
    for (int i = 0; i < MSG_MAX; i++) m.push_back(8'(i + 1));
    send_msg(m, "R2");
    m.delete();
    for (int i = 0; i < MSG_MAX + 2; i++) m.push_back(8'(8'h40 + i));
    send_msg(m, "R3");
    drain();
    bp_tx = 1'b1;
    m = {8'h7E, 8'h00, 8'h00, 8'h81}; send_msg(m, "R4");
    m = {8'hFF, 8'h10};               send_msg(m, "R4");
    drain();
    bp_tx = 1'b0;
    chk("R2 serial queue drained", 32'(q_tx.size()), 32'd0);

    // receive: routing and back-pressure
    m = {8'h11, 8'h22, 8'h33};        rx_msg(m);
    m = {8'hFF, 8'h01};               rx_msg(m);
    m = {8'h00, 8'h42, 8'h00};        rx_msg(m);
    m = {8'hFF};                      rx_msg(m);
    m.delete();
    for (int i = 0; i < MSG_MAX; i++) m.push_back(8'(8'hA0 + i));
    rx_msg(m);
    bp_rx = 1'b1;
    m = {8'h05, 8'h00, 8'h06};        rx_msg(m);
    m = {8'hFF, 8'h00, 8'h09};        rx_msg(m);
    drain();
    bp_rx = 1'b0;
    chk("R5 CAN queue drained", 32'(q_can.size()), 32'd0);
    chk("R6 local queue drained", 32'(q_ctl.size()), 32'd0);
    chk("R5 R6 no error on good frames", 32'(err_seen), 32'd0);

    // receive: damaged frames, each followed by a good one
    m = {8'h04, 8'h10, 8'h20, 8'h05, 8'h00};  rx_bad(m);   // R7 sum not zero
    m = {8'h21, 8'h22};                       rx_msg(m);
    m = {8'h10};
    for (int i = 0; i < 15; i++) m.push_back(8'h01);
    m.push_back(8'h00);                       rx_bad(m);   // R8 overlong
    m = {8'h31};                              rx_msg(m);
    m = {8'h05, 8'h11, 8'h22, 8'h00};         rx_bad(m);   // R9 code past delimiter
    m = {8'hFF, 8'h55};                       rx_msg(m);
    drain();
    chk("R7 R8 R9 error pulses", 32'(err_seen), 32'(err_exp));
    m = {8'h00, 8'h00, 8'h00};                rx_bytes(m);  // R10 empty frames
    drain();
    chk("R10 empty frames raise no error", 32'(err_seen), 32'(err_exp));
    m = {8'h02, 8'h07, 8'h00};                rx_bad(m);   // R10 too short
    m = {8'h61, 8'h62, 8'h63};                rx_msg(m);
    drain();
    chk("R10 short frame error", 32'(err_seen), 32'(err_exp));
    chk("R7 R8 R9 R10 dropped frames emit nothing", 32'(q_can.size() + q_ctl.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule